// File: doc/BRIEF.md
# Interrupt line service and coalescing unit

This unit watches a set of interrupt input lines and decides, pin by pin, when an interrupt message should go out. Line activity arrives as one assert or deassert event per cycle. Each pin is either edge-sensitive or level-sensitive, and it may be masked. The vector, destination, mode and mask of each pin come from an external register file. A rewrite strobe tells the unit that a pin's entry was just written. The unit records a line-high bitmap. It holds back repeated level interrupts with a per-pin in-service flag (remote IRR), which an end-of-interrupt notice carrying a vector clears. After every end-of-interrupt it services again the lines that are still high.

One designated pin, the timer-tick pin, is held back even in edge mode. After it delivers in edge mode, a dedicated hold flag blocks further deliveries on that pin until an end-of-interrupt with its vector arrives. Software that counts ticks can read this flag to see that ticks were merged. Every delivery that has been decided goes into a pending bitmap. The pending bitmap drains one pin per cycle, lowest pin first. Each delivery is a one-cycle pulse that carries the pin index, vector and destination. The receiver is assumed to accept every pulse.

Top module: `irq_line_coalescer`

## Requirements
- R1: A deassert event (`line_evt_assert`=0) clears the pin's line-high bit and never causes a delivery.
- R2: On an edge-mode pin (`cfg_level_mode` bit = 0), an assert is ignored while the pin's line-high bit is already set. After a deassert, the next assert delivers again.
- R3: A masked pin (`cfg_mask` bit = 1) never delivers, but its asserts still set the line-high bit. An edge pin that was asserted while masked therefore does not deliver when it is unmasked, and it delivers again only after a deassert followed by an assert.
- R4: A delivery on a level-mode pin (`cfg_level_mode` bit = 1) sets `remote_irr[p]`. While that bit is set, further asserts on the pin do not deliver.
- R5: An end-of-interrupt clears `remote_irr[p]` of every level-mode pin whose vector equals `eoi_vector`. Pins with another vector keep their flag.
- R6: After an end-of-interrupt, every level-mode pin whose line is still high is serviced as a fresh assert. It delivers if it is unmasked and its flag is clear.
- R7: The pin at index TICK_PIN (8) sets `tick_hold` when it delivers in edge mode. While `tick_hold` is set, asserts on that pin do not deliver. An end-of-interrupt whose vector equals that pin's vector clears `tick_hold`.
- R8: An entry rewrite (`cfg_wr_valid`, `cfg_wr_pin`) in edge mode clears that pin's `remote_irr`. A rewrite in level mode keeps the flag, and it services the pin again if the pin is unmasked and its line is high. Masking and then unmasking therefore leaves `remote_irr` unchanged.
- R9: Deliveries that become due in the same cycle go out one per cycle, lowest pin index first. A delivery decided at clock edge k appears on `dlv_valid` after edge k+1 if no lower pin is pending.
- R10: `dlv_valid` is a pulse with no handshake. While it is high, `dlv_pin`, `dlv_vector` and `dlv_dest` carry the pin index and that pin's configured vector and destination.
- R11: Inputs that arrive in the same cycle are applied in a fixed order: end-of-interrupt first, then the entry rewrite, then the line event.
- R12: A synchronous reset clears all line-high bits, `remote_irr`, `tick_hold`, the pending bitmap and `dlv_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_evt_valid | input | 1 | A line event is present this cycle |
| line_evt_pin | input | PIN_W | Pin index of the line event |
| line_evt_assert | input | 1 | 1 = line raised, 0 = line lowered |
| cfg_level_mode | input | NUM_PINS | Per pin: 1 = level mode, 0 = edge mode |
| cfg_mask | input | NUM_PINS | Per pin: 1 = masked |
| cfg_vector | input | NUM_PINS*VEC_W | Per-pin vector, pin p at bits [p*VEC_W +: VEC_W] |
| cfg_dest | input | NUM_PINS*DEST_W | Per-pin destination, pin p at bits [p*DEST_W +: DEST_W] |
| cfg_wr_valid | input | 1 | An entry was just rewritten |
| cfg_wr_pin | input | PIN_W | Pin whose entry was rewritten |
| eoi_valid | input | 1 | End-of-interrupt notice |
| eoi_vector | input | VEC_W | Vector carried by the end-of-interrupt |
| dlv_valid | output | 1 | Delivery pulse |
| dlv_pin | output | PIN_W | Pin being delivered |
| dlv_vector | output | VEC_W | Vector of the delivered pin |
| dlv_dest | output | DEST_W | Destination of the delivered pin |
| remote_irr | output | NUM_PINS | Per-pin in-service flag |
| tick_hold | output | 1 | Tick-pin edge coalescing flag |

## Verification
The bench builds the unit with its default parameters: 24 pins, the tick pin at index 8, and 8-bit vectors and destinations. This size lets the stimulus reach both ends of the arbitration range (pins 0 and 23). Two level pins (3 and 23) share one vector, so a single end-of-interrupt releases both of them and makes them compete in the same cycle. Masked pins and the tick pin run alongside them in the random phase, so the effects of the same-cycle ordering show up against the reference model.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;

    localparam int IRQ_PINS_DEF = 24;
    localparam int IRQ_VEC_W_DEF = 8;
    localparam int IRQ_DEST_W_DEF = 8;
    localparam int IRQ_TICK_DEF = 8;

    // Working state of one pin while the cycle's inputs are applied in turn.
    typedef struct packed {
        logic lvl;   // line currently high
        logic rirr;  // level interrupt in service
        logic hold;  // tick pin edge coalescing flag
        logic fire;  // a delivery was decided this cycle
    } pin_st_t;

    function automatic pin_st_t try_deliver(pin_st_t s, logic lvl_mode, logic masked,
                                            logic is_tick);
        pin_st_t r;
        r = s;
        if (!masked && !(lvl_mode && s.rirr) && !(is_tick && s.hold)) begin
            r.fire = 1'b1;
            if (lvl_mode)
                r.rirr = 1'b1;
            else if (is_tick)
                r.hold = 1'b1;
        end
        return r;
    endfunction

    function automatic pin_st_t line_assert(pin_st_t s, logic lvl_mode, logic masked,
                                            logic is_tick);
        pin_st_t r;
        r = s;
        if (lvl_mode || !s.lvl) begin
            r.lvl = 1'b1;
            r = try_deliver(r, lvl_mode, masked, is_tick);
        end
        return r;
    endfunction

    function automatic pin_st_t line_drop(pin_st_t s);
        pin_st_t r;
        r = s;
        r.lvl = 1'b0;
        return r;
    endfunction

    function automatic pin_st_t eoi_step(pin_st_t s, logic lvl_mode, logic masked,
                                         logic is_tick, logic vec_hit);
        pin_st_t r;
        r = s;
        if (vec_hit) begin
            if (is_tick) r.hold = 1'b0;
            if (lvl_mode) r.rirr = 1'b0;
        end
        if (r.lvl) r = line_assert(r, lvl_mode, masked, is_tick);
        return r;
    endfunction

    function automatic pin_st_t rewrite_step(pin_st_t s, logic lvl_mode, logic masked,
                                             logic is_tick);
        pin_st_t r;
        r = s;
        if (!lvl_mode)
            r.rirr = 1'b0;
        else if (r.lvl && !masked)
            r = try_deliver(r, lvl_mode, masked, is_tick);
        return r;
    endfunction

endpackage

// File: rtl/irq_pin_slice.sv
module irq_pin_slice
    import irq_coal_pkg::*;
#(
    parameter int VEC_W   = IRQ_VEC_W_DEF,
    parameter bit IS_TICK = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             level_mode,
    input  logic             masked,
    input  logic [VEC_W-1:0] vector,
    input  logic             evt_hit,
    input  logic             evt_assert,
    input  logic             wr_hit,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vector,
    input  logic             grant,
    output logic             pend,
    output logic             rirr,
    output logic             hold
);

    logic    lvl_q, rirr_q, hold_q, pend_q;
    pin_st_t cur, s_eoi, s_wr, s_nxt;

    // Order within one cycle: end-of-interrupt, entry rewrite, line event.
    always_comb begin
        cur   = '{lvl: lvl_q, rirr: rirr_q, hold: hold_q, fire: 1'b0};
        s_eoi = cur;
        if (eoi_valid)
            s_eoi = eoi_step(cur, level_mode, masked, IS_TICK, vector == eoi_vector);
        s_wr = s_eoi;
        if (wr_hit)
            s_wr = rewrite_step(s_eoi, level_mode, masked, IS_TICK);
        s_nxt = s_wr;
        if (evt_hit)
            s_nxt = evt_assert ? line_assert(s_wr, level_mode, masked, IS_TICK)
                               : line_drop(s_wr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= 1'b0;
            rirr_q <= 1'b0;
            hold_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            lvl_q  <= s_nxt.lvl;
            rirr_q <= s_nxt.rirr;
            hold_q <= s_nxt.hold;
            pend_q <= (pend_q && !grant) || s_nxt.fire;
        end
    end

    assign pend = pend_q;
    assign rirr = rirr_q;
    assign hold = hold_q;

endmodule

// File: rtl/irq_grant_arb.sv
module irq_grant_arb
    import irq_coal_pkg::*;
#(
    parameter int NUM_PINS = IRQ_PINS_DEF,
    parameter int VEC_W    = IRQ_VEC_W_DEF,
    parameter int DEST_W   = IRQ_DEST_W_DEF,
    localparam int PIN_W   = $clog2(NUM_PINS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_PINS-1:0]        pend,
    input  logic [NUM_PINS*VEC_W-1:0]  cfg_vector,
    input  logic [NUM_PINS*DEST_W-1:0] cfg_dest,
    output logic [NUM_PINS-1:0]        grant,
    output logic                       dlv_valid,
    output logic [PIN_W-1:0]           dlv_pin,
    output logic [VEC_W-1:0]           dlv_vector,
    output logic [DEST_W-1:0]          dlv_dest
);

    logic             any;
    logic [PIN_W-1:0] idx;

    // Scan downward so that the last hit, the lowest index, wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (pend[i]) begin
                any = 1'b1;
                idx = PIN_W'(i);
            end
        end
        grant = any ? (NUM_PINS'(1) << idx) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dlv_valid  <= 1'b0;
            dlv_pin    <= '0;
            dlv_vector <= '0;
            dlv_dest   <= '0;
        end else begin
            dlv_valid  <= any;
            dlv_pin    <= idx;
            dlv_vector <= cfg_vector[int'(idx)*VEC_W +: VEC_W];
            dlv_dest   <= cfg_dest[int'(idx)*DEST_W +: DEST_W];
        end
    end

endmodule

// File: rtl/irq_line_coalescer.sv
module irq_line_coalescer
    import irq_coal_pkg::*;
#(
    parameter int NUM_PINS = IRQ_PINS_DEF,
    parameter int VEC_W    = IRQ_VEC_W_DEF,
    parameter int DEST_W   = IRQ_DEST_W_DEF,
    parameter int TICK_PIN = IRQ_TICK_DEF,
    localparam int PIN_W   = $clog2(NUM_PINS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       line_evt_valid,
    input  logic [PIN_W-1:0]           line_evt_pin,
    input  logic                       line_evt_assert,
    input  logic [NUM_PINS-1:0]        cfg_level_mode,
    input  logic [NUM_PINS-1:0]        cfg_mask,
    input  logic [NUM_PINS*VEC_W-1:0]  cfg_vector,
    input  logic [NUM_PINS*DEST_W-1:0] cfg_dest,
    input  logic                       cfg_wr_valid,
    input  logic [PIN_W-1:0]           cfg_wr_pin,
    input  logic                       eoi_valid,
    input  logic [VEC_W-1:0]           eoi_vector,
    output logic                       dlv_valid,
    output logic [PIN_W-1:0]           dlv_pin,
    output logic [VEC_W-1:0]           dlv_vector,
    output logic [DEST_W-1:0]          dlv_dest,
    output logic [NUM_PINS-1:0]        remote_irr,
    output logic                       tick_hold
);

    logic [NUM_PINS-1:0] pend_vec, grant_vec, hold_vec;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        irq_pin_slice #(
            .VEC_W  (VEC_W),
            .IS_TICK(p == TICK_PIN)
        ) u_slice (
            .clk       (clk),
            .rst       (rst),
            .level_mode(cfg_level_mode[p]),
            .masked    (cfg_mask[p]),
            .vector    (cfg_vector[p*VEC_W +: VEC_W]),
            .evt_hit   (line_evt_valid && (line_evt_pin == PIN_W'(p))),
            .evt_assert(line_evt_assert),
            .wr_hit    (cfg_wr_valid && (cfg_wr_pin == PIN_W'(p))),
            .eoi_valid (eoi_valid),
            .eoi_vector(eoi_vector),
            .grant     (grant_vec[p]),
            .pend      (pend_vec[p]),
            .rirr      (remote_irr[p]),
            .hold      (hold_vec[p])
        );
    end

    // Only the tick slice can ever set its hold flag.
    assign tick_hold = |hold_vec;

    irq_grant_arb #(
        .NUM_PINS(NUM_PINS),
        .VEC_W   (VEC_W),
        .DEST_W  (DEST_W)
    ) u_arb (
        .clk       (clk),
        .rst       (rst),
        .pend      (pend_vec),
        .cfg_vector(cfg_vector),
        .cfg_dest  (cfg_dest),
        .grant     (grant_vec),
        .dlv_valid (dlv_valid),
        .dlv_pin   (dlv_pin),
        .dlv_vector(dlv_vector),
        .dlv_dest  (dlv_dest)
    );

endmodule

// File: rtl/irq_line_coalescer_chk.sv
module irq_line_coalescer_chk #(
    parameter int NUM_PINS = 24,
    parameter int TICK_PIN = 8,
    localparam int PIN_W   = $clog2(NUM_PINS)
) (
    input logic                clk,
    input logic                rst,
    input logic                line_evt_valid,
    input logic [PIN_W-1:0]    line_evt_pin,
    input logic                line_evt_assert,
    input logic                cfg_wr_valid,
    input logic                eoi_valid,
    input logic                dlv_valid,
    input logic [PIN_W-1:0]    dlv_pin,
    input logic [NUM_PINS-1:0] remote_irr,
    input logic                tick_hold
);

    // R10: a delivered pin index is always a real pin
    assert_pin_range_R10: assert property (@(posedge clk) disable iff (rst)
        dlv_valid |-> (int'(dlv_pin) < NUM_PINS));

    // R4: an in-service flag only rises after an assert, a rewrite or an EOI
    assert_irr_set_cause_R4: assert property (@(posedge clk) disable iff (rst)
        ((remote_irr & ~$past(remote_irr)) != '0) |->
            $past((line_evt_valid && line_evt_assert) || cfg_wr_valid || eoi_valid));

    // R5: an in-service flag only falls after an EOI or a rewrite
    assert_irr_clear_cause_R5: assert property (@(posedge clk) disable iff (rst)
        ((~remote_irr & $past(remote_irr)) != '0) |-> $past(eoi_valid || cfg_wr_valid));

    // R7: the tick hold flag rises only after an assert on the tick pin
    assert_hold_set_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(tick_hold) |->
            $past(line_evt_valid && line_evt_assert && (int'(line_evt_pin) == TICK_PIN)));

    // R7: the tick hold flag falls only after an EOI
    assert_hold_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(tick_hold) |-> $past(eoi_valid));

endmodule

bind irq_line_coalescer irq_line_coalescer_chk #(
    .NUM_PINS(NUM_PINS),
    .TICK_PIN(TICK_PIN)
) i_chk (
    .clk            (clk),
    .rst            (rst),
    .line_evt_valid (line_evt_valid),
    .line_evt_pin   (line_evt_pin),
    .line_evt_assert(line_evt_assert),
    .cfg_wr_valid   (cfg_wr_valid),
    .eoi_valid      (eoi_valid),
    .dlv_valid      (dlv_valid),
    .dlv_pin        (dlv_pin),
    .remote_irr     (remote_irr),
    .tick_hold      (tick_hold)
);

// File: tb/test_irq_line_coalescer.sv
`timescale 1ns/1ps
module test_irq_line_coalescer;

    localparam int NP = 24, VW = 8, DW = 8, TICK = 8, PW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          evt_v = 1'b0, evt_a = 1'b0, wr_v = 1'b0, eoi_v = 1'b0;
    logic [PW-1:0] evt_pin = '0, wr_pin = '0;
    logic [VW-1:0] eoi_vec = '0;

    logic [VW-1:0] c_vec [NP];
    logic [DW-1:0] c_dst [NP];
    logic          c_lvl [NP];
    logic          c_msk [NP];

    logic [NP-1:0]    cfg_level_mode, cfg_mask;
    logic [NP*VW-1:0] cfg_vector;
    logic [NP*DW-1:0] cfg_dest;

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            cfg_level_mode[p]      = c_lvl[p];
            cfg_mask[p]            = c_msk[p];
            cfg_vector[p*VW +: VW] = c_vec[p];
            cfg_dest[p*DW +: DW]   = c_dst[p];
        end
    end

    logic          dlv_valid, tick_hold;
    logic [PW-1:0] dlv_pin;
    logic [VW-1:0] dlv_vector;
    logic [DW-1:0] dlv_dest;
    logic [NP-1:0] remote_irr;

    irq_line_coalescer i_irq_line_coalescer (
        .clk(clk), .rst(rst),
        .line_evt_valid(evt_v), .line_evt_pin(evt_pin), .line_evt_assert(evt_a),
        .cfg_level_mode(cfg_level_mode), .cfg_mask(cfg_mask),
        .cfg_vector(cfg_vector), .cfg_dest(cfg_dest),
        .cfg_wr_valid(wr_v), .cfg_wr_pin(wr_pin),
        .eoi_valid(eoi_v), .eoi_vector(eoi_vec),
        .dlv_valid(dlv_valid), .dlv_pin(dlv_pin), .dlv_vector(dlv_vector),
        .dlv_dest(dlv_dest), .remote_irr(remote_irr), .tick_hold(tick_hold)
    );

    // ---------------- behavioural reference model ----------------
    bit m_lvl [NP];
    bit m_rirr [NP];
    bit m_pend [NP];
    bit m_hold;
    bit e_valid;
    int e_pin;
    logic [VW-1:0] e_vec;
    logic [DW-1:0] e_dst;

    function automatic void m_try(int p);
        if (c_msk[p]) return;
        if (c_lvl[p] && m_rirr[p]) return;
        if (p == TICK && m_hold) return;
        if (c_lvl[p]) m_rirr[p] = 1'b1;
        else if (p == TICK) m_hold = 1'b1;
        m_pend[p] = 1'b1;
    endfunction

    function automatic void m_assert(int p);
        if (!c_lvl[p] && m_lvl[p]) return;
        m_lvl[p] = 1'b1;
        m_try(p);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NP; p++) begin
                m_lvl[p] = 0; m_rirr[p] = 0; m_pend[p] = 0;
            end
            m_hold = 0;
            e_valid = 0;
        end else begin
            e_valid = 0;
            for (int p = 0; p < NP; p++) begin
                if (m_pend[p] && !e_valid) begin
                    e_valid = 1; e_pin = p; e_vec = c_vec[p]; e_dst = c_dst[p];
                    m_pend[p] = 0;
                end
            end
            if (eoi_v) begin
                for (int p = 0; p < NP; p++) begin
                    if (c_vec[p] == eoi_vec) begin
                        if (p == TICK) m_hold = 0;
                        if (c_lvl[p]) m_rirr[p] = 0;
                    end
                    if (m_lvl[p]) m_assert(p);
                end
            end
            if (wr_v) begin
                if (!c_lvl[wr_pin]) m_rirr[wr_pin] = 0;
                else if (m_lvl[wr_pin] && !c_msk[wr_pin]) m_try(int'(wr_pin));
            end
            if (evt_v) begin
                if (evt_a) m_assert(int'(evt_pin));
                else m_lvl[evt_pin] = 0;
            end
        end
    end

    // ---------------- checking ----------------
    int checks = 0, fails = 0, n_dlv = 0;
    int last_pin = -1, prev_pin = -1;
    logic [VW-1:0] last_vec;
    logic [DW-1:0] last_dst;
    string ph = "R12";
    bit done = 0;

    task automatic expect_int(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [NP-1:0] er;
        for (int p = 0; p < NP; p++) er[p] = m_rirr[p];
        expect_int(ph, "dlv_valid", int'(dlv_valid), int'(e_valid));
        if (dlv_valid && e_valid) begin
            checks++;
            if (int'(dlv_pin) != e_pin || dlv_vector != e_vec || dlv_dest != e_dst) begin
                fails++;
                $display("FAIL %s R10 delivery actual=%0d/%h/%h expected=%0d/%h/%h", ph,
                         dlv_pin, dlv_vector, dlv_dest, e_pin, e_vec, e_dst);
            end
        end
        checks++;
        if (remote_irr !== er) begin
            fails++;
            $display("FAIL %s remote_irr actual=%h expected=%h", ph, remote_irr, er);
        end
        expect_int(ph, "tick_hold", int'(tick_hold), int'(m_hold));
        if (dlv_valid) begin
            n_dlv++; prev_pin = last_pin; last_pin = int'(dlv_pin);
            last_vec = dlv_vector; last_dst = dlv_dest;
        end
    endtask

    task automatic cyc(bit ev, int pin, bit a, bit e, int vv);
        @(negedge clk);
        compare();
        evt_v = ev; evt_pin = PW'(pin); evt_a = a;
        wr_v = 0; eoi_v = e; eoi_vec = VW'(vv);
    endtask

    task automatic line(int pin, bit a); cyc(1, pin, a, 0, 0); endtask
    task automatic eoi(int vv); cyc(0, 0, 0, 1, vv); endtask
    task automatic idle(int n); for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0); endtask

    task automatic set_entry(int p, bit l, bit m);
        @(negedge clk);
        compare();
        c_lvl[p] = l; c_msk[p] = m;
        evt_v = 0; eoi_v = 0; wr_v = 1; wr_pin = PW'(p);
    endtask

    int base;

    initial begin
        for (int p = 0; p < NP; p++) begin
            c_vec[p] = VW'(8'h40 + p); c_dst[p] = DW'(p); c_lvl[p] = 0; c_msk[p] = 1;
        end
        c_vec[3] = 8'h31;  c_dst[3] = 8'h13;  c_lvl[3] = 1;  c_msk[3] = 0;
        c_vec[5] = 8'h52;  c_dst[5] = 8'h15;  c_msk[5] = 0;
        c_vec[8] = 8'h80;  c_dst[8] = 8'h18;  c_msk[8] = 0;
        c_vec[23] = 8'h31; c_dst[23] = 8'h2a; c_lvl[23] = 1; c_msk[23] = 0;

        repeat (3) @(negedge clk);
        expect_int("R12", "dlv_valid in reset", int'(dlv_valid), 0);
        expect_int("R12", "remote_irr in reset", int'(remote_irr), 0);
        expect_int("R12", "tick_hold in reset", int'(tick_hold), 0);
        rst = 0;

        ph = "R1"; base = n_dlv;
        line(5, 0); idle(4);
        expect_int("R1", "deliveries after deassert", n_dlv - base, 0);

        ph = "R2"; base = n_dlv;
        line(5, 1); idle(2); line(5, 1); idle(2); line(5, 0); line(5, 1); idle(4);
        expect_int("R2", "edge deliveries", n_dlv - base, 2);
        expect_int("R2", "edge pin", last_pin, 5);

        ph = "R3"; base = n_dlv;
        set_entry(5, 0, 1); line(5, 0); line(5, 1); idle(4);
        set_entry(5, 0, 0); idle(4); line(5, 1); idle(4);
        expect_int("R3", "masked and stale asserts", n_dlv - base, 0);
        line(5, 0); line(5, 1); idle(4);
        expect_int("R3", "after unmask and fresh edge", n_dlv - base, 1);
        line(5, 0);

        ph = "R4"; base = n_dlv;
        line(3, 1); idle(4);
        expect_int("R4", "level delivery", n_dlv - base, 1);
        expect_int("R4", "remote_irr[3] set", int'(remote_irr[3]), 1);
        line(3, 0); line(3, 1); idle(4);
        expect_int("R4", "coalesced assert", n_dlv - base, 1);

        ph = "R6"; base = n_dlv;
        eoi(8'h31); idle(4);
        expect_int("R6", "reinjected after EOI", n_dlv - base, 1);
        expect_int("R6", "remote_irr[3] set again", int'(remote_irr[3]), 1);
        ph = "R5"; base = n_dlv;
        eoi(8'h99); idle(3);
        expect_int("R5", "other vector keeps flag", int'(remote_irr[3]), 1);
        line(3, 0); eoi(8'h31); idle(4);
        expect_int("R5", "flag cleared", int'(remote_irr[3]), 0);
        expect_int("R5", "no delivery with line low", n_dlv - base, 0);

        ph = "R7"; base = n_dlv;
        line(8, 1); idle(2); line(8, 0); line(8, 1); idle(4);
        expect_int("R7", "tick coalesced", n_dlv - base, 1);
        expect_int("R7", "tick_hold set", int'(tick_hold), 1);
        eoi(8'h80); idle(4);
        expect_int("R7", "tick_hold cleared", int'(tick_hold), 0);
        expect_int("R7", "no edge reinject", n_dlv - base, 1);
        line(8, 0); line(8, 1); idle(4);
        expect_int("R7", "tick after release", n_dlv - base, 2);
        line(8, 0); eoi(8'h80);

        ph = "R8"; base = n_dlv;
        set_entry(3, 1, 1); line(3, 1); idle(4);
        expect_int("R8", "masked level", n_dlv - base, 0);
        set_entry(3, 1, 0); idle(4);
        expect_int("R8", "fires on unmask", n_dlv - base, 1);
        set_entry(3, 1, 1); idle(2); set_entry(3, 1, 0); idle(4);
        expect_int("R8", "mask cycle keeps flag", int'(remote_irr[3]), 1);
        expect_int("R8", "no extra delivery", n_dlv - base, 1);
        set_entry(3, 0, 0); idle(2);
        expect_int("R8", "edge write clears flag", int'(remote_irr[3]), 0);
        set_entry(3, 1, 0); idle(4);
        expect_int("R8", "level write reservices", n_dlv - base, 2);
        line(3, 0); eoi(8'h31);

        ph = "R9"; base = n_dlv;
        line(3, 1); line(23, 1); idle(4);
        eoi(8'h31); idle(4);
        expect_int("R9", "both reinjected", n_dlv - base, 4);
        expect_int("R9", "first of pair", prev_pin, 3);
        expect_int("R9", "second of pair", last_pin, 23);
        expect_int("R10", "vector of pin 23", int'(last_vec), 8'h31);
        expect_int("R10", "dest of pin 23", int'(last_dst), 8'h2a);

        ph = "R11"; base = n_dlv;
        cyc(1, 3, 0, 1, 8'h31); idle(4);
        expect_int("R11", "EOI before deassert", n_dlv - base, 2);
        cyc(1, 3, 1, 1, 8'h31); idle(4);
        expect_int("R11", "EOI before assert", n_dlv - base, 4);
        line(3, 0); line(23, 0); eoi(8'h31); idle(4);

        ph = "R11 random";
        begin
            int rp[6] = '{0, 3, 5, 8, 12, 23};
            int rv[4] = '{8'h31, 8'h52, 8'h80, 8'h4c};
            for (int n = 0; n < 3000; n++) begin
                int op, p;
                op = int'($urandom % 10);
                p = rp[$urandom % 6];
                if (op < 5) line(p, 1'($urandom));
                else if (op == 5) eoi(rv[$urandom % 4]);
                else if (op == 6) cyc(1, p, 1'($urandom), 1, rv[$urandom % 4]);
                else if (op == 7) set_entry(p, 1'($urandom), 1'($urandom % 3 == 0));
                else idle(1);
            end
        end

        ph = "R12";
        @(negedge clk); compare(); rst = 1; evt_v = 0; wr_v = 0; eoi_v = 0;
        idle(2);
        @(negedge clk); compare(); rst = 0;
        expect_int("R12", "remote_irr after reset", int'(remote_irr), 0);
        expect_int("R12", "tick_hold after reset", int'(tick_hold), 0);
        expect_int("R12", "dlv_valid after reset", int'(dlv_valid), 0);
        idle(4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule